// File: doc/BRIEF.md
# Transmit Descriptor Ring Walker

This block drains a software-built ring of transmit descriptors held in a shared word-wide memory and turns each referenced buffer into a byte stream with a valid/ready handshake. Software fills the descriptors and their buffers, sets the ownership bit in each, and pulses `poll`. The walker then fetches descriptors one after another. For each owned descriptor it reads the buffer byte by byte, presents the bytes on the output, and marks the end of a frame on the final byte of a frame's last buffer. When a buffer is done, the walker hands the descriptor back by writing its status word with the ownership bit cleared. If the descriptor asks for it, the walker also raises a one-cycle service pulse.

Traversal follows the descriptors themselves. A wrap flag sends the walker back to the programmed ring base; otherwise it steps to the next 8-byte slot. When the walker meets a descriptor that software does not own, it parks on that descriptor. It fetches that descriptor again only when software pulses `poll`. The memory port has a one-cycle read latency and is always granted. A descriptor is two words: status and length, then the buffer byte address. Bytes sit big-endian inside each word.

Top module: `txr_walker`

## Requirements
- R1: After reset, `mem_req`, `tx_valid` and `tx_irq` are 0, and the first `poll` makes the walker fetch its first descriptor word at byte address `ring_base`.
- R2: Descriptor word 0 holds the ownership (ready) flag in bit 31, wrap in bit 29, interrupt in bit 28, last-in-frame in bit 27 and the byte count in bits 15:0. Word 1, at the descriptor address plus 4, holds the buffer's byte address. Within a memory word, the byte at offset 0 sits in bits 31:24.
- R3: A fetched descriptor whose ready bit is 0 produces no bytes and no write. The walker stays on that descriptor and fetches it again only after a `poll` pulse.
- R4: The buffer bytes of a ready descriptor leave on `tx_data` in ascending address order, starting at any byte alignment, exactly byte-count of them.
- R5: While `tx_valid` is 1 and `tx_ready` is 0, `tx_valid`, `tx_data` and `tx_eof` hold their values into the next cycle, so no byte is dropped or repeated.
- R6: `tx_eof` is 1 exactly with the final byte of a descriptor whose last bit is 1, and never without `tx_valid`.
- R7: After a buffer's final byte is accepted, the walker writes word 0 back with bit 31 cleared and every other bit unchanged.
- R8: After closing a descriptor with wrap set, the next fetch is at `ring_base`. Otherwise it is at the closed descriptor's address plus 8. Slots beyond a wrap descriptor are never fetched.
- R9: `tx_irq` is a one-cycle pulse, issued together with the closing write, for exactly those descriptors whose interrupt bit is 1.
- R10: A ready descriptor with byte count 0 is closed (R7, R9 apply) without any byte on the output.
- R11: After a close, the walker fetches the next descriptor without needing another `poll`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ring_base | input | 32 | Byte address of the first ring descriptor |
| poll | input | 1 | Start / re-poll pulse, acted on while idle |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Write enable for the request |
| mem_addr | output | 32 | Byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid the cycle after a read request |
| tx_data | output | 8 | Output byte |
| tx_valid | output | 1 | Output byte valid |
| tx_ready | input | 1 | Consumer accepts the byte |
| tx_eof | output | 1 | Final byte of a frame |
| tx_irq | output | 1 | Buffer-serviced event pulse |

## Verification
A descriptor pointer that wraps or steps wrongly would show up within one descriptor. A slot past the wrap would be fetched and streamed, or a slot would be skipped, and the byte sequence would be wrong at once. A bad remaining-count or buffer cursor shows in the same buffer as a short, long, shifted or repeated byte run, and an `tx_eof` on the wrong byte. Losing the captured status word corrupts the write-back seen in memory and the interrupt pulse count right when that descriptor closes. A stuck ready-check shows as output from a descriptor software never handed over, or as a walker that never stops.

// File: rtl/txr_pkg.sv
package txr_pkg;
  localparam int AW          = 32;
  localparam int DW          = 32;
  localparam int LEN_W       = 16;
  localparam int DESC_BYTES  = 8;
  localparam int BIT_READY   = 31;
  localparam int BIT_WRAP    = 29;
  localparam int BIT_INTR    = 28;
  localparam int BIT_LAST    = 27;

  typedef enum logic [3:0] {
    S_IDLE, S_RD0, S_GET0, S_RD1, S_GET1, S_RDB, S_GETB, S_SEND, S_CLOSE
  } walk_state_t;

  // byte lane 0 is the most significant byte of a word
  function automatic logic [7:0] lane_byte(input logic [DW-1:0] w, input logic [1:0] lane);
    logic [4:0] sh;
    sh = 5'(3 - lane) << 3;
    return 8'(w >> sh);
  endfunction

  function automatic logic [AW-1:0] next_desc(input logic [AW-1:0] cur,
                                              input logic [AW-1:0] base,
                                              input logic wrap);
    return wrap ? base : cur + AW'(DESC_BYTES);
  endfunction

  function automatic logic [DW-1:0] hand_back(input logic [DW-1:0] w0);
    logic [DW-1:0] r;
    r = w0;
    r[BIT_READY] = 1'b0;
    return r;
  endfunction

  function automatic logic [AW-1:0] word_of(input logic [AW-1:0] a);
    return {a[AW-1:2], 2'b00};
  endfunction
endpackage

// File: rtl/txr_ring_ptr.sv
module txr_ring_ptr
  import txr_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          advance,
  input  logic          wrap,
  input  logic [AW-1:0] base,
  output logic [AW-1:0] cur
);
  always_ff @(posedge clk) begin
    if (!rst_n)       cur <= '0;
    else if (load)    cur <= base;
    else if (advance) cur <= next_desc(cur, base, wrap);
  end

  // R8
  wrap_to_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && wrap && !load) |=> cur == $past(base));
  // R8
  step_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !wrap && !load) |=> cur == $past(cur) + AW'(DESC_BYTES));
endmodule

// File: rtl/txr_buf_cursor.sv
module txr_buf_cursor
  import txr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             step,
  input  logic [AW-1:0]    ptr_in,
  input  logic [LEN_W-1:0] len_in,
  output logic [AW-1:0]    ptr,
  output logic [LEN_W-1:0] rem,
  output logic             final_byte,
  output logic             empty
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr <= '0;
      rem <= '0;
    end else if (load) begin
      ptr <= ptr_in;
      rem <= len_in;
    end else if (step) begin
      ptr <= ptr + AW'(1);
      rem <= rem - LEN_W'(1);
    end
  end

  assign final_byte = (rem == LEN_W'(1));
  assign empty      = (rem == '0);

  // R4
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> !empty);
  // R4
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> ptr == $past(ptr) + AW'(1));
endmodule

// File: rtl/txr_walker.sv
module txr_walker
  import txr_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [31:0]   ring_base,
  input  logic          poll,
  output logic          mem_req,
  output logic          mem_we,
  output logic [31:0]   mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata,
  output logic [7:0]    tx_data,
  output logic          tx_valid,
  input  logic          tx_ready,
  output logic          tx_eof,
  output logic          tx_irq
);
  walk_state_t      state, state_nx;
  logic [DW-1:0]    w0;
  logic [7:0]       byte_q;
  logic             fresh;
  logic [AW-1:0]    cur, ptr;
  logic [LEN_W-1:0] rem;
  logic             final_byte, empty;

  // named internal events
  logic ev_poll, ev_owned, ev_xfer, ev_close, ev_load_buf;
  assign ev_poll     = (state == S_IDLE) && poll;
  assign ev_owned    = (state == S_GET0) && mem_rdata[BIT_READY];
  assign ev_xfer     = (state == S_SEND) && tx_ready;
  assign ev_close    = (state == S_CLOSE);
  assign ev_load_buf = (state == S_GET1);

  txr_ring_ptr u_ring (
    .clk(clk), .rst_n(rst_n), .load(ev_poll && fresh), .advance(ev_close),
    .wrap(w0[BIT_WRAP]), .base(ring_base), .cur(cur)
  );

  txr_buf_cursor u_cur (
    .clk(clk), .rst_n(rst_n), .load(ev_load_buf), .step(ev_xfer),
    .ptr_in(mem_rdata), .len_in(w0[LEN_W-1:0]), .ptr(ptr), .rem(rem),
    .final_byte(final_byte), .empty(empty)
  );

  always_comb begin
    state_nx = state;
    unique case (state)
      S_IDLE:  if (poll) state_nx = S_RD0;
      S_RD0:   state_nx = S_GET0;
      S_GET0:  state_nx = ev_owned ? S_RD1 : S_IDLE;
      S_RD1:   state_nx = S_GET1;
      S_GET1:  state_nx = (w0[LEN_W-1:0] == '0) ? S_CLOSE : S_RDB;
      S_RDB:   state_nx = S_GETB;
      S_GETB:  state_nx = S_SEND;
      S_SEND:  if (tx_ready) state_nx = final_byte ? S_CLOSE : S_RDB;
      S_CLOSE: state_nx = S_RD0;
      default: state_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      w0     <= '0;
      byte_q <= '0;
      fresh  <= 1'b1;
    end else begin
      state <= state_nx;
      if (state == S_GET0) w0 <= mem_rdata;
      if (state == S_GETB) byte_q <= lane_byte(mem_rdata, ptr[1:0]);
      if (ev_poll) fresh <= 1'b0;
    end
  end

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = cur;
    mem_wdata = '0;
    unique case (state)
      S_RD0:   mem_req = 1'b1;
      S_RD1:   begin mem_req = 1'b1; mem_addr = cur + AW'(4); end
      S_RDB:   begin mem_req = 1'b1; mem_addr = word_of(ptr); end
      S_CLOSE: begin mem_req = 1'b1; mem_we = 1'b1; mem_wdata = hand_back(w0); end
      default: ;
    endcase
  end

  assign tx_valid = (state == S_SEND);
  assign tx_data  = byte_q;
  assign tx_eof   = tx_valid && final_byte && w0[BIT_LAST];
  assign tx_irq   = ev_close && w0[BIT_INTR];

  // R5
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_eof)));
  // R6
  eof_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_eof |-> tx_valid);
  // R7
  close_clears_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_req && !mem_wdata[BIT_READY]));
  // R9
  irq_with_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_irq |-> mem_we);
  // R9
  irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_irq |=> !tx_irq);
  // R3
  no_byte_unowned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == S_GET0) && !ev_owned) |=> (!tx_valid && !mem_req));
endmodule

// File: tb/sim_txr_walker.sv
module sim_txr_walker;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [31:0] ring_base = 32'h80;
  logic poll = 1'b0;
  logic mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [7:0] tx_data;
  logic tx_valid, tx_eof, tx_irq;
  logic tx_ready = 1'b1;

  always #5 clk = ~clk;

  txr_walker u0 (
    .clk(clk), .rst_n(rst_n), .ring_base(ring_base), .poll(poll),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_eof(tx_eof), .tx_irq(tx_irq)
  );

  // memory model: 256 words, one-cycle read latency
  logic [31:0] mem [256];
  always @(posedge clk) begin
    if (mem_req && mem_we) mem[mem_addr[9:2]] <= mem_wdata;
    if (mem_req && !mem_we) mem_rdata <= mem[mem_addr[9:2]];
  end

  // stimulus table: {ready, wrap, intr, last, len[15:0], buf[15:0]}
  localparam int NDESC = 6;
  localparam logic [35:0] VEC [NDESC] = '{
    {4'b1010, 16'd3, 16'h0201},
    {4'b1001, 16'd2, 16'h0210},
    {4'b1010, 16'd0, 16'h0220},
    {4'b1011, 16'd5, 16'h0233},
    {4'b1101, 16'd1, 16'h0240},
    {4'b1011, 16'd4, 16'h0250}
  };

  int checks = 0, fails = 0;
  int cyc = 0;
  logic [7:0] exp_data [64];
  logic       exp_eof  [64];
  int nexp = 0, exp_irq = 0;
  logic [7:0] got_data [64];
  logic       got_eof  [64];
  int ngot = 0, irq_cnt = 0;
  logic armed = 1'b0;
  logic [31:0] first_addr = '0;
  logic [31:0] w0_img [NDESC];

  function automatic logic [7:0] pat(input int d, input int k);
    return 8'((d * 37 + k * 11 + 5) & 255);
  endfunction

  task automatic put_byte(input logic [31:0] a, input logic [7:0] v);
    mem[a[9:2]][31 - 8*a[1:0] -: 8] = v;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_up;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // consumer back-pressure, changed just after the edge
  initial forever begin
    @(posedge clk); #1;
    tx_ready = !((cyc % 5) == 2 || (cyc % 7) == 3);
  end

  // collector samples at the falling edge
  always @(negedge clk) begin
    if (tx_valid && tx_ready && ngot < 64) begin
      got_data[ngot] <= tx_data;
      got_eof[ngot]  <= tx_eof;
      ngot <= ngot + 1;
    end
    if (tx_irq) irq_cnt <= irq_cnt + 1;
    if (armed && mem_req) begin
      first_addr <= mem_addr;
      armed <= 1'b0;
    end
  end

  task automatic pulse_poll;
    @(posedge clk); #1 poll = 1'b1;
    @(posedge clk); #1 poll = 1'b0;
  endtask

  task automatic wait_quiet;
    int q = 0;
    while (q < 12) begin
      @(negedge clk);
      if (!mem_req && !tx_valid) q++; else q = 0;
    end
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=idle");
    finish_up();
  end

  initial begin
    bit wrapped;
    int base_ngot, base_irq;
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 mem_req", {31'b0, mem_req}, 0);
    chk("R1 tx_valid", {31'b0, tx_valid}, 0);
    chk("R1 tx_irq", {31'b0, tx_irq}, 0);

    // table walk: build the ring and the expected stream
    wrapped = 1'b0;
    for (int d = 0; d < NDESC; d++) begin
      logic [31:0] da, ba;
      int len;
      da  = ring_base + 32'(8 * d);
      len = int'(VEC[d][31:16]);
      ba  = {16'b0, VEC[d][15:0]};
      w0_img[d] = {VEC[d][35], 1'b0, VEC[d][34], VEC[d][33], VEC[d][32], 11'b0, VEC[d][31:16]};
      mem[da[9:2]] = w0_img[d];
      mem[da[9:2] + 8'd1] = ba;
      for (int k = 0; k < len; k++) put_byte(ba + 32'(k), pat(d, k));
      if (!wrapped) begin
        for (int k = 0; k < len; k++) begin
          exp_data[nexp] = pat(d, k);
          exp_eof[nexp]  = VEC[d][32] && (k == len - 1);
          nexp++;
        end
        if (VEC[d][33]) exp_irq++;
        if (VEC[d][34]) wrapped = 1'b1;
      end
    end

    armed = 1'b1;
    pulse_poll();
    wait_quiet();
    chk("R1 first fetch at ring_base", first_addr, ring_base);
    chk("R4/R10/R11 byte count", 32'(ngot), 32'(nexp));
    for (int n = 0; n < nexp; n++) begin
      chk("R4/R5 byte value", {24'b0, got_data[n]}, {24'b0, exp_data[n]});
      chk("R6 eof flag", {31'b0, got_eof[n]}, {31'b0, exp_eof[n]});
    end
    chk("R9 irq pulses", 32'(irq_cnt), 32'(exp_irq));
    for (int d = 0; d < 5; d++)
      chk("R2/R7 word0 write-back", mem[(ring_base[9:2] + 8'(2*d))], w0_img[d] & 32'h7FFF_FFFF);
    chk("R8 slot past wrap untouched", mem[ring_base[9:2] + 8'd10], w0_img[5]);

    // R3: re-own first descriptor, no poll -> nothing happens
    base_ngot = ngot;
    base_irq  = irq_cnt;
    mem[ring_base[9:2]] = w0_img[0];
    repeat (30) @(negedge clk);
    chk("R3 no output without poll", 32'(ngot), 32'(base_ngot));
    pulse_poll();
    wait_quiet();
    chk("R3 repoll byte count", 32'(ngot - base_ngot), 32'd3);
    for (int k = 0; k < 3; k++) begin
      chk("R3/R4 repoll byte", {24'b0, got_data[base_ngot + k]}, {24'b0, pat(0, k)});
      chk("R6 no eof on non-last", {31'b0, got_eof[base_ngot + k]}, 32'd0);
    end
    chk("R9 repoll irq", 32'(irq_cnt - base_irq), 32'd1);
    chk("R7 repoll write-back", mem[ring_base[9:2]], w0_img[0] & 32'h7FFF_FFFF);
    finish_up();
  end
endmodule